// File: doc/BRIEF.md
# Clear-on-read interrupt flag register

This block gathers three interrupt sources for a timekeeping subsystem: a periodic tick, an alarm match and an update-ended notice. Each source sends a single-cycle pulse. The block holds each pulse in a sticky flag inside a read-only status byte. Every flag latches whether or not its source is enabled. The enable bits are taken from a control byte supplied by the surrounding register file. A summary bit and an active-low interrupt request reflect only the flags whose sources are enabled.

Software services the interrupt by reading the status byte. The read returns the current flags in the same cycle, and all three flags clear together at the following clock edge. If an event arrives in the same cycle as the read, its flag is set again rather than lost. The rate-divider, alarm-compare and update logic that produce the pulses sit outside this block.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, all flags are clear, the status byte reads 0x00 and `irqN` is high.
- R2: A pulse on `periodicEvt`, `alarmEvt` or `updateEvt` sets status bit 6, bit 5 or bit 4 respectively from the next cycle onward. This happens regardless of the enable bits.
- R3: A set flag stays set while no status read occurs.
- R4: A cycle with `statusRd` high returns the current flags on `statusData`, and all three flags are clear from the next cycle.
- R5: An event in the same cycle as a status read leaves its flag set after the read.
- R6: Status bit 7 equals (bit6 AND ctrlB[6]) OR (bit5 AND ctrlB[5]) OR (bit4 AND ctrlB[4]).
- R7: `irqN` is low exactly when status bit 7 is 1.
- R8: Status bits 3 to 0 always read as zero.
- R9: A change of the enable bits affects bit 7 and `irqN` in the same cycle, without waiting for a clock edge.
- R10: The control byte bits other than 6, 5 and 4 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodicEvt | input | 1 | Single-cycle periodic tick pulse |
| alarmEvt | input | 1 | Single-cycle alarm match pulse |
| updateEvt | input | 1 | Single-cycle update-ended pulse |
| statusRd | input | 1 | Status byte read strobe, clears flags at the next edge |
| ctrlB | input | 8 | Control byte; bits 6, 5 and 4 enable periodic, alarm and update |
| statusData | output | 8 | Status byte: summary, three flags, zero nibble |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle that the request pin mirrors the summary bit and that the low nibble is zero. They also check that each event sets its flag at the next cycle, that a flag rises only after its own event, and that flags hold without a read and clear after one. Other behaviours can be shown only by the bench's scenarios, which compare each cycle against a reference model. These are: latching while the source is disabled, the event that coincides with a read, enable changes taking effect in the same cycle, and control bits outside the enable field having no effect.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int NUM_SRC = 3;

  typedef struct packed {
    logic [NUM_SRC-1:0] setFlags;  // {periodic, alarm, update}
    logic [NUM_SRC-1:0] enMask;    // matching enables
    logic               clearAll;  // status read in this cycle
  } flag_strobes_t;
endpackage

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EN_LSB  = 4
) (
  input  logic              periodicEvt,
  input  logic              alarmEvt,
  input  logic              updateEvt,
  input  logic              statusRd,
  input  logic [DATA_W-1:0] ctrlB,
  output flag_strobes_t     strobes
);
  localparam int EN_MSB = EN_LSB + NUM_SRC - 1;

  always_comb begin
    strobes.setFlags = {periodicEvt, alarmEvt, updateEvt};
    strobes.enMask   = ctrlB[EN_MSB:EN_LSB];
    strobes.clearAll = statusRd;
  end
endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  flag_strobes_t     strobes,
  output logic [DATA_W-1:0] statusData,
  output logic              irqN
);
  localparam int FLAG_MSB = FLAG_LSB + NUM_SRC - 1;
  localparam int SUM_BIT  = DATA_W - 1;

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] flagsNext;
  logic               summary;

  // A new event wins over the clear so it is never dropped.
  always_comb begin
    flagsNext = strobes.clearAll ? '0 : flags;
    flagsNext = flagsNext | strobes.setFlags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNext;
  end

  assign summary = |(flags & strobes.enMask);

  always_comb begin
    statusData                    = '0;
    statusData[FLAG_MSB:FLAG_LSB] = flags;
    statusData[SUM_BIT]           = summary;
  end

  assign irqN = ~summary;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodicEvt,
  input  logic              alarmEvt,
  input  logic              updateEvt,
  input  logic              statusRd,
  input  logic [DATA_W-1:0] ctrlB,
  output logic [DATA_W-1:0] statusData,
  output logic              irqN
);
  flag_strobes_t strobes;

  irq_flag_ctrl #(.DATA_W(DATA_W), .EN_LSB(FLAG_LSB)) i_ctrl (
    .periodicEvt(periodicEvt),
    .alarmEvt   (alarmEvt),
    .updateEvt  (updateEvt),
    .statusRd   (statusRd),
    .ctrlB      (ctrlB),
    .strobes    (strobes)
  );

  irq_flag_dp #(.DATA_W(DATA_W), .FLAG_LSB(FLAG_LSB)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .statusData(statusData),
    .irqN      (irqN)
  );
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       periodicEvt,
  input logic       alarmEvt,
  input logic       updateEvt,
  input logic       statusRd,
  input logic [7:0] statusData,
  input logic       irqN
);
  // R7
  irq_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqN == !statusData[7]);

  // R8
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusData[3:0] == 4'h0);

  // R2
  periodic_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodicEvt |=> statusData[6]);

  // R2
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> statusData[5]);

  // R2
  update_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt |=> statusData[4]);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusData[5] && !statusRd) |=> statusData[5]);

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !periodicEvt) |=> !statusData[6]);

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusData[4]) |-> $past(updateEvt));
endmodule

bind irq_flag_reg irq_flag_reg_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .periodicEvt(periodicEvt),
  .alarmEvt   (alarmEvt),
  .updateEvt  (updateEvt),
  .statusRd   (statusRd),
  .statusData (statusData),
  .irqN       (irqN)
);

// File: tb/test_irq_flag_reg.sv
`timescale 1ns/1ps
module test_irq_flag_reg;
  logic       clk = 0;
  logic       rstN = 0;
  logic       periodicEvt = 0, alarmEvt = 0, updateEvt = 0, statusRd = 0;
  logic [7:0] ctrlB = 0;
  logic [7:0] statusData;
  logic       irqN;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  typedef struct {
    logic [7:0] status;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  logic [2:0] model = 3'b000;  // {periodic, alarm, update}

  always #5 clk = ~clk;

  irq_flag_reg i_irq_flag_reg (
    .clk(clk), .rstN(rstN), .periodicEvt(periodicEvt), .alarmEvt(alarmEvt),
    .updateEvt(updateEvt), .statusRd(statusRd), .ctrlB(ctrlB),
    .statusData(statusData), .irqN(irqN)
  );

  // Driver: apply one cycle of stimulus and push the expected outputs.
  task automatic step(input logic [2:0] evts, input logic rd,
                      input logic [7:0] ctl, input string tag);
    exp_t e;
    logic sum;
    @(negedge clk);
    {periodicEvt, alarmEvt, updateEvt} = evts;
    statusRd = rd;
    ctrlB    = ctl;
    sum      = |(model & ctl[6:4]);
    e.status = {sum, model, 4'h0};
    e.irq    = !sum;
    e.tag    = tag;
    expQ.push_back(e);
    model = (rd ? 3'b000 : model) | evts;
  endtask

  // Monitor: sample between edges and compare against the queue.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checkCnt++;
        if (statusData !== e.status) begin
          failCnt++;
          $display("FAIL %s status got %h expected %h", e.tag, statusData, e.status);
        end
        checkCnt++;
        if (irqN !== e.irq) begin
          failCnt++;
          $display("FAIL %s irqN got %b expected %b", e.tag, irqN, e.irq);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    step(3'b000, 0, 8'h00, "R1 reset state");
    step(3'b100, 0, 8'h00, "R2 periodic pulse");
    step(3'b000, 0, 8'h00, "R2 periodic latched with enable off");
    step(3'b010, 0, 8'h00, "R2 alarm pulse");
    step(3'b001, 0, 8'h00, "R2 update pulse");
    step(3'b000, 0, 8'h00, "R6 all flags no enable");
    step(3'b000, 0, 8'h00, "R3 hold");
    step(3'b000, 0, 8'h20, "R9 alarm enable same cycle");
    step(3'b000, 0, 8'h8F, "R10 other control bits ignored");
    step(3'b000, 0, 8'hAF, "R10 junk plus alarm enable");
    step(3'b000, 0, 8'h10, "R7 update enable");
    step(3'b000, 1, 8'h70, "R4 read returns flags");
    step(3'b000, 0, 8'h70, "R4 cleared after read");
    step(3'b000, 0, 8'h70, "R8 low nibble zero");
    step(3'b010, 0, 8'h40, "R6 alarm disabled while set");
    step(3'b000, 0, 8'h40, "R6 no summary for disabled flag");
    step(3'b100, 1, 8'h40, "R5 read with periodic event");
    step(3'b000, 0, 8'h40, "R5 periodic survives read");
    step(3'b000, 0, 8'h00, "R9 enable removed");
    step(3'b111, 1, 8'h70, "R5 all events with read");
    step(3'b000, 0, 8'h70, "R5 all flags survive");
    step(3'b000, 1, 8'h7F, "R4 second read");
    step(3'b000, 0, 8'hFF, "R4 all clear");
    step(3'b000, 0, 8'hFF, "R3 clear holds");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule